// File: doc/BRIEF.md
# Core and System Clock Ratio Controller

This block produces two clock-enable streams, one for the core domain and one for the system/peripheral domain, both qualified against a single fast clock. The fast clock stands in for the multiplied clock. A reference strobe, one fast-clock cycle wide, marks each edge of the slow reference input. The reference input itself is specified between 10 and 33 MHz.

At full speed every fast-clock cycle is a base tick. While bypassed, only reference strobes are base ticks. Each domain divides the base ticks by its own programmable ratio. The system ratio is never allowed to be finer than the core ratio.

A small write port programs these settings:
- a bypass request and a multiplier-off request;
- a multiplier factor;
- the two divider ratios;
- a settle length.

A multiplier factor is only taken while the block is bypassed. It becomes the factor in effect at the moment the block returns to full speed.

The behaviour is held in a four-state machine:
- `ST_FULL`: full speed.
- `ST_BYPASS`: base ticks come from the reference.
- `ST_MULT_OFF`: the multiplier is switched off and the block is still bypassed.
- `ST_SETTLE`: the multiplier has been re-enabled and a settle counter is running.

The transitions are:
- `FULL->BYPASS`: the bypass or off request is set.
- `BYPASS->MULT_OFF`: the off request is set.
- `BYPASS->FULL`: both requests are clear. This transition applies the pending factor.
- `MULT_OFF->SETTLE`: the off request is cleared. This loads the settle counter.
- `SETTLE->MULT_OFF`: the off request is set again.
- `SETTLE->BYPASS`: the counter expires. This sets the ready bit.

A combinational read port returns the settings in effect.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: A write to address 1 is accepted only when the data value is between 1 and 31. Any other value leaves the pending factor unchanged. The pending factor reads back at read address 4.
- R2: Address 2 sets the core ratio and address 3 sets the system ratio, each from 1 to 15. A value of zero, or a value above 15, is ignored. The core enable pulses once every core-ratio base ticks, and the system enable once every system-ratio base ticks.
- R3: The system divider uses the larger of the programmed system ratio and the programmed core ratio, so the system enable is never faster than the core enable. Read address 3 returns the ratio actually loaded.
- R4: Address 0 bit 0 requests bypass. Outside `ST_FULL`, base ticks are the reference strobes. In `ST_FULL`, every cycle is a base tick. Read address 0 bit 0 reads 1 whenever the block is not in `ST_FULL`.
- R5: A multiplier write made in `ST_FULL` is ignored. The pending factor is copied to the factor in effect (read address 1) only on the `BYPASS->FULL` transition.
- R6: Address 0 bit 1 requests multiplier off. It is honoured only from the bypassed states. In `ST_MULT_OFF`, read address 0 bit 1 reads 1 and the ready bit (read address 0 bit 2) reads 0.
- R7: Clearing the off request loads the settle counter from address 4. The block returns to `ST_BYPASS` after settle-length + 1 cycles in `ST_SETTLE`, and the ready bit is set at that moment.
- R8: A new divider ratio is loaded only when the previous count reaches zero, so no enable period is shortened by a ratio change.
- R9: Read addresses 1, 2 and 3 report the values in effect, which may differ from pending writes. Unused read addresses return 0.
- R10: After reset the block is in `ST_FULL` with ready set. The factor in effect and the pending factor are both 8, the core ratio is 1, the system ratio is 2, the settle length is 4, and both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running clock modelling the multiplied clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe marking each reference clock edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 multiplier, 2 core ratio, 3 system ratio, 4 settle length |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read-back address |
| rd_data | output | 8 | Read-back data (settings in effect, status) |
| core_en | output | 1 | Core-domain clock enable |
| sys_en | output | 1 | System-domain clock enable |

## Verification
Both enables are tried in two regimes:
- At full speed, where every cycle is a base tick, the divider ratios alone set the pulse spacing.
- While bypassed, the pulse spacing depends on the reference strobe period, which separates a wrong tick source from a wrong ratio.

Ratio pairs are chosen with the system ratio below the core ratio, then far above it, to tell the clamp apart from plain division. Changes made mid-count show whether reloads wait for the count boundary. Multiplier values of 0, 40, a legal factor, and a legal factor written at full speed separate range rejection, state gating and deferred application.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
    localparam int MULT_W   = 5;
    localparam int DIV_W    = 4;
    localparam int SETTLE_W = 8;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;

    typedef enum logic [1:0] {
        ST_FULL     = 2'd0,
        ST_BYPASS   = 2'd1,
        ST_MULT_OFF = 2'd2,
        ST_SETTLE   = 2'd3
    } ratio_state_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MULT   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CDIV   = 3'd2;
    localparam logic [ADDR_W-1:0] A_SDIV   = 3'd3;
    localparam logic [ADDR_W-1:0] A_SETTLE = 3'd4;
endpackage

// File: rtl/ratio_divider.sv
module ratio_divider #(
    parameter int DIV_W   = 4,
    parameter int RST_DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_in,
    output logic             en,
    output logic [DIV_W-1:0] div_eff
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            div_eff <= DIV_W'(RST_DIV);
            en      <= 1'b0;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_q   <= div_in - DIV_W'(1);
                div_eff <= div_in;
                en      <= 1'b1;
            end else begin
                cnt_q <= cnt_q - DIV_W'(1);
                en    <= 1'b0;
            end
        end else begin
            en <= 1'b0;
        end
    end
endmodule

// File: rtl/ratio_fsm.sv
module ratio_fsm
    import clk_ratio_pkg::*;
#(
    parameter int SETTLE_WIDTH = SETTLE_W,
    parameter int MULT_WIDTH   = MULT_W,
    parameter int RST_MULT     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_bypass,
    input  logic                    req_off,
    input  logic [SETTLE_WIDTH-1:0] settle_len,
    input  logic [MULT_WIDTH-1:0]   mult_pend,
    output ratio_state_e            state,
    output logic                    ready,
    output logic [MULT_WIDTH-1:0]   mult_eff
);
    ratio_state_e            state_d;
    logic [SETTLE_WIDTH-1:0] cnt_q;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_FULL:     if (req_bypass || req_off) state_d = ST_BYPASS;
            ST_BYPASS:   if (req_off) state_d = ST_MULT_OFF;
                         else if (!req_bypass) state_d = ST_FULL;
            ST_MULT_OFF: if (!req_off) state_d = ST_SETTLE;
            ST_SETTLE:   if (req_off) state_d = ST_MULT_OFF;
                         else if (cnt_q == '0) state_d = ST_BYPASS;
            default:     state_d = ST_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FULL;
        else        state <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready    <= 1'b1;
            cnt_q    <= '0;
            mult_eff <= MULT_WIDTH'(RST_MULT);
        end else begin
            unique case (state)
                ST_FULL: ;
                ST_BYPASS: begin
                    if (state_d == ST_MULT_OFF) ready <= 1'b0;
                    if (state_d == ST_FULL) mult_eff <= mult_pend;
                end
                ST_MULT_OFF: if (state_d == ST_SETTLE) cnt_q <= settle_len;
                ST_SETTLE: begin
                    if (state_d == ST_MULT_OFF) ready <= 1'b0;
                    else if (state_d == ST_BYPASS) ready <= 1'b1;
                    else cnt_q <= cnt_q - SETTLE_WIDTH'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
    import clk_ratio_pkg::*;
#(
    parameter int RST_MULT   = 8,
    parameter int RST_CDIV   = 1,
    parameter int RST_SDIV   = 2,
    parameter int RST_SETTLE = 4,
    parameter int MAX_MULT   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              core_en,
    output logic              sys_en
);
    localparam int NDOM = 2;
    localparam int DIV_MAX = (1 << DIV_W) - 1;

    logic                req_bypass_q, req_off_q;
    logic [MULT_W-1:0]   mult_pend_q, mult_eff;
    logic [DIV_W-1:0]    cdiv_req_q, sdiv_req_q, sdiv_clamped;
    logic [SETTLE_W-1:0] settle_q;
    ratio_state_e        state;
    logic                ready, base_tick;
    logic [DIV_W-1:0]    div_in  [NDOM];
    logic [DIV_W-1:0]    div_eff [NDOM];
    logic                dom_en  [NDOM];

    wire mult_ok = (wr_data >= DATA_W'(1)) && (wr_data <= DATA_W'(MAX_MULT));
    wire div_ok  = (wr_data >= DATA_W'(1)) && (wr_data <= DATA_W'(DIV_MAX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_bypass_q <= 1'b0;
            req_off_q    <= 1'b0;
            mult_pend_q  <= MULT_W'(RST_MULT);
            cdiv_req_q   <= DIV_W'(RST_CDIV);
            sdiv_req_q   <= DIV_W'(RST_SDIV);
            settle_q     <= SETTLE_W'(RST_SETTLE);
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    req_bypass_q <= wr_data[0];
                    req_off_q    <= wr_data[1];
                end
                A_MULT:   if (mult_ok && state != ST_FULL) mult_pend_q <= wr_data[MULT_W-1:0];
                A_CDIV:   if (div_ok) cdiv_req_q <= wr_data[DIV_W-1:0];
                A_SDIV:   if (div_ok) sdiv_req_q <= wr_data[DIV_W-1:0];
                A_SETTLE: settle_q <= wr_data[SETTLE_W-1:0];
                default: ;
            endcase
        end
    end

    ratio_fsm #(.SETTLE_WIDTH(SETTLE_W), .MULT_WIDTH(MULT_W), .RST_MULT(RST_MULT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_bypass (req_bypass_q),
        .req_off    (req_off_q),
        .settle_len (settle_q),
        .mult_pend  (mult_pend_q),
        .state      (state),
        .ready      (ready),
        .mult_eff   (mult_eff)
    );

    assign base_tick    = (state == ST_FULL) ? 1'b1 : ref_tick;
    assign sdiv_clamped = (sdiv_req_q < cdiv_req_q) ? cdiv_req_q : sdiv_req_q;
    assign div_in[0]    = cdiv_req_q;
    assign div_in[1]    = sdiv_clamped;

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        ratio_divider #(.DIV_W(DIV_W), .RST_DIV(g == 0 ? RST_CDIV : RST_SDIV)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (base_tick),
            .div_in  (div_in[g]),
            .en      (dom_en[g]),
            .div_eff (div_eff[g])
        );
    end

    assign core_en = dom_en[0];
    assign sys_en  = dom_en[1];

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            3'd0: rd_data = {5'b0, ready, state == ST_MULT_OFF, state != ST_FULL};
            3'd1: rd_data = DATA_W'(mult_eff);
            3'd2: rd_data = DATA_W'(div_eff[0]);
            3'd3: rd_data = DATA_W'(div_eff[1]);
            3'd4: rd_data = DATA_W'(mult_pend_q);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/clk_ratio_ctrl_chk.sv
module clk_ratio_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_tick,
    input logic [1:0] st,
    input logic       ready,
    input logic [4:0] mult_eff,
    input logic [3:0] cdiv_eff,
    input logic [3:0] sdiv_eff,
    input logic [3:0] cdiv_req,
    input logic       core_en
);
    always_comb begin
        if (rst_n) assert_mult_range_R1: assert (mult_eff >= 5'd1 && mult_eff <= 5'd31);
    end

    assert_sys_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdiv_eff) |-> sdiv_eff >= $past(cdiv_req));

    assert_bypass_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && $past(st) != 2'd0) |-> $past(ref_tick));

    assert_mult_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mult_eff) |-> ($past(st) == 2'd1 && st == 2'd0));

    assert_off_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd2) |-> !ready);

    assert_boundary_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cdiv_eff) |-> core_en);
endmodule

bind clk_ratio_ctrl clk_ratio_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .st       (state),
    .ready    (ready),
    .mult_eff (mult_eff),
    .cdiv_eff (div_eff[0]),
    .sdiv_eff (div_eff[1]),
    .cdiv_req (cdiv_req_q),
    .core_en  (core_en)
);

// File: tb/clk_ratio_ctrl_tb.sv
module clk_ratio_ctrl_tb;
    logic       clk = 0, rst_n = 0, ref_tick = 0, wr_en = 0;
    logic [2:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       core_en, sys_en;
    int checks = 0, failures = 0;
    bit done = 0;

    clk_ratio_ctrl u_dut (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .core_en(core_en), .sys_en(sys_en));

    always #2 clk = ~clk;

    // reference model (0 full, 1 bypass, 2 off, 3 settle)
    int m_st, m_byp, m_off, m_mp, m_me, m_cr, m_sr, m_sl, m_sc, m_rdy;
    int m_cc, m_cd, m_ce, m_scn, m_sd, m_se;

    task automatic m_reset();
        m_st = 0; m_byp = 0; m_off = 0; m_mp = 8; m_me = 8; m_cr = 1; m_sr = 2;
        m_sl = 4; m_sc = 0; m_rdy = 1; m_cc = 0; m_cd = 1; m_ce = 0; m_scn = 0; m_sd = 2; m_se = 0;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            int tick, sreq, ns;
            tick = (m_st == 0) ? 1 : int'(ref_tick);
            sreq = (m_sr > m_cr) ? m_sr : m_cr;
            m_ce = 0; m_se = 0;
            if (tick != 0) begin
                if (m_cc == 0) begin m_ce = 1; m_cd = m_cr; m_cc = m_cr - 1; end else m_cc--;
                if (m_scn == 0) begin m_se = 1; m_sd = sreq; m_scn = sreq - 1; end else m_scn--;
            end
            ns = m_st;
            case (m_st)
                0: if (m_byp != 0 || m_off != 0) ns = 1;
                1: if (m_off != 0) begin ns = 2; m_rdy = 0; end
                   else if (m_byp == 0) begin ns = 0; m_me = m_mp; end
                2: if (m_off == 0) begin ns = 3; m_sc = m_sl; end
                default: if (m_off != 0) begin ns = 2; m_rdy = 0; end
                   else if (m_sc == 0) begin ns = 1; m_rdy = 1; end
                   else m_sc--;
            endcase
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_byp = int'(wr_data[0]); m_off = int'(wr_data[1]); end
                    3'd1: if (m_st != 0 && wr_data >= 1 && wr_data <= 31) m_mp = int'(wr_data);
                    3'd2: if (wr_data >= 1 && wr_data <= 15) m_cr = int'(wr_data);
                    3'd3: if (wr_data >= 1 && wr_data <= 15) m_sr = int'(wr_data);
                    3'd4: m_sl = int'(wr_data);
                    default: ;
                endcase
            end
            m_st = ns;
        end
    end

    function automatic int m_rd(input int a);
        case (a)
            0: return (m_rdy << 2) | ((m_st == 2 ? 1 : 0) << 1) | (m_st != 0 ? 1 : 0);
            1: return m_me;
            2: return m_cd;
            3: return m_sd;
            4: return m_mp;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // every-cycle enable comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 R4 R8 core_en", int'(core_en), m_ce);
            chk("R2 R3 sys_en", int'(sys_en), m_se);
        end
    end

    // reference strobe every 5 cycles
    initial forever begin
        repeat (4) @(negedge clk) ref_tick = 0;
        @(negedge clk) ref_tick = 1;
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input string tag, input int a, input int exp);
        @(negedge clk); rd_addr = 3'(a); #1;
        chk(tag, int'(rd_data), m_rd(a));
        chk(tag, int'(rd_data), exp);
    endtask

    initial begin
        #(4 * 150000);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 core_en reset", int'(core_en), 0);
        chk("R10 sys_en reset", int'(sys_en), 0);
        rst_n = 1;
        rd("R10 status", 0, 4); rd("R10 mult", 1, 8); rd("R10 core div", 2, 1); rd("R10 sys div", 3, 2);
        repeat (20) @(negedge clk);
        wr(1, 5); rd("R5 full-speed mult ignored", 4, 8);
        wr(2, 3); wr(3, 2); repeat (30) @(negedge clk);
        rd("R3 clamp", 3, 3); rd("R2 core div", 2, 3);
        wr(2, 0); rd("R2 zero rejected", 2, 3);
        wr(2, 16); repeat (10) @(negedge clk); rd("R2 over-range rejected", 2, 3);
        wr(3, 7); repeat (30) @(negedge clk); rd("R2 sys div", 3, 7);
        wr(0, 1); repeat (3) @(negedge clk);
        rd("R4 bypassed", 0, 5);
        repeat (60) @(negedge clk);
        wr(1, 0); rd("R1 zero rejected", 4, 8);
        wr(1, 40); rd("R1 forty rejected", 4, 8);
        wr(1, 31); rd("R1 max accepted", 4, 31);
        wr(1, 12); rd("R9 pending", 4, 12); rd("R9 effective", 1, 8);
        wr(0, 3); repeat (3) @(negedge clk);
        rd("R6 off status", 0, 3);
        wr(4, 6); wr(0, 1); repeat (2) @(negedge clk);
        rd("R7 settling not ready", 0, 1);
        repeat (12) @(negedge clk);
        rd("R7 ready after settle", 0, 5);
        wr(2, 2); repeat (25) @(negedge clk);
        wr(0, 0); repeat (3) @(negedge clk);
        rd("R5 mult applied", 1, 12); rd("R4 full status", 0, 4);
        wr(2, 5); repeat (3) @(negedge clk); wr(2, 1); repeat (20) @(negedge clk);
        rd("R8 core div", 2, 1);
        wr(3, 15); repeat (40) @(negedge clk); rd("R3 sys slow", 3, 15);
        rd("R9 unused", 6, 0);
        repeat (10) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule